// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A purely combinational adder that sums two unsigned operands and a carry-in. Carries are never rippled from bit to bit. The word is split into fixed-width groups. Each group computes per-bit generate and propagate terms, forms its internal carries in flattened sum-of-products form from its own carry-in, and reduces its bits to one group generate and one group propagate term.

A second-level lookahead unit takes those group terms and the adder carry-in. It produces the carry-in of every group and the final carry-out, all in flattened form. The unit also reduces the group terms to one generate and one propagate term for the whole word. These two terms are exported, so that several instances plus one more lookahead unit can form a wider adder. The default build is 16 bits in four 4-bit groups.

Top module: `lookahead_adder`

## Requirements
- R1: `sum` equals the low 16 bits of `op_a + op_b + carry_in` for every operand pair.
- R2: `carry_out` equals bit 16 of `op_a + op_b + carry_in`.
- R3: `blk_gen` is 1 exactly when `op_a + op_b` (with no carry-in) carries out of bit 15; it does not depend on `carry_in`.
- R4: `blk_prop` is 1 exactly when every bit position has at least one of `op_a`, `op_b` set, i.e. `(op_a | op_b) == 16'hFFFF`.
- R5: A carry entering bit 0 crosses all four groups: `16'hFFFF + 16'h0001` with carry-in 0, and `16'hFFFF + 16'h0000` with carry-in 1, both give sum 0 and carry-out 1.
- R6: `carry_out` equals `blk_gen | (blk_prop & carry_in)`, so the exported pair is enough to cascade instances.
- R7: A carry made in the top bit of one group reaches the lowest bit of the next group, for example `16'h000F + 16'h0001 = 16'h0010` and `16'h0F00 + 16'h0100 = 16'h1000`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |
| blk_prop | output | 1 | Whole-word propagate term |
| blk_gen | output | 1 | Whole-word generate term |

## Verification
All four outputs are combinational. They are due in the same cycle as the operands that produce them, with no register on the path. The bench changes the inputs just after a rising edge and compares the outputs at the following falling edge, half a period later. The reference takes each stimulus from a queue and recomputes sum, carry-out, word generate and word propagate with integer arithmetic on that stimulus. Operand sets include the full-word carry chain, alternating propagate patterns, group-boundary carries, and random values.

// File: rtl/cla_pkg.sv
package cla_pkg;

   localparam int unsigned MAX_SPAN = 32;

   // Flattened carry into position idx: OR over every generate below idx
   // of that generate ANDed with all propagates between it and idx,
   // plus the incoming carry ANDed with every propagate below idx.
   function automatic logic lookahead(input logic [MAX_SPAN-1:0] gen,
                                      input logic [MAX_SPAN-1:0] prop,
                                      input logic                cin,
                                      input int unsigned         idx);
      logic acc;
      logic term;
      acc = 1'b0;
      for (int unsigned j = 0; j < MAX_SPAN; j++) begin
         if (j < idx) begin
            term = gen[j];
            for (int unsigned k = 0; k < MAX_SPAN; k++) begin
               if (k > j && k < idx) term = term & prop[k];
            end
            acc = acc | term;
         end
      end
      term = cin;
      for (int unsigned k = 0; k < MAX_SPAN; k++) begin
         if (k < idx) term = term & prop[k];
      end
      return acc | term;
   endfunction

endpackage

// File: rtl/cla_group.sv
module cla_group
   import cla_pkg::*;
#(
   parameter int unsigned GW = 4
) (
   input  logic [GW-1:0] a,
   input  logic [GW-1:0] b,
   input  logic          cin,
   output logic [GW-1:0] s,
   output logic          bp,
   output logic          bg
);

   if (GW < 1 || GW > MAX_SPAN) begin : gw_range_bad
      $error("cla_group: GW out of range");
   end

   logic [GW-1:0]       g;
   logic [GW-1:0]       p;
   logic [GW-1:0]       c;
   logic [MAX_SPAN-1:0] g_ext;
   logic [MAX_SPAN-1:0] p_ext;

   assign g     = a & b;
   assign p     = a | b;
   assign g_ext = MAX_SPAN'(g);
   assign p_ext = MAX_SPAN'(p);

   for (genvar i = 0; i < GW; i++) begin : bit_carry
      if (i == 0) begin : first
         assign c[i] = cin;
      end else begin : rest
         assign c[i] = lookahead(g_ext, p_ext, cin, i);
      end
      assign s[i] = a[i] ^ b[i] ^ c[i];
   end

   assign bg = lookahead(g_ext, p_ext, 1'b0, GW);
   assign bp = &p;

   always_comb begin
      for (int i = 0; i + 1 < GW; i++) begin
         // R1
         bit_gen_chk: assert (!g[i] || c[i+1])
            else $error("generate at bit %0d gave no carry", i);
         // R1
         bit_kill_chk: assert (p[i] || !c[i+1])
            else $error("killed bit %0d still carried", i);
      end
   end

endmodule

// File: rtl/cla_unit.sv
module cla_unit
   import cla_pkg::*;
#(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] gp,
   input  logic [N-1:0] gg,
   input  logic         cin,
   output logic [N-1:0] cgrp,
   output logic         cout,
   output logic         up,
   output logic         ug
);

   if (N < 1 || N > MAX_SPAN) begin : n_range_bad
      $error("cla_unit: N out of range");
   end

   logic [MAX_SPAN-1:0] g_ext;
   logic [MAX_SPAN-1:0] p_ext;

   assign g_ext = MAX_SPAN'(gg);
   assign p_ext = MAX_SPAN'(gp);

   for (genvar k = 0; k < N; k++) begin : grp_carry
      if (k == 0) begin : first
         assign cgrp[k] = cin;
      end else begin : rest
         assign cgrp[k] = lookahead(g_ext, p_ext, cin, k);
      end
   end

   assign cout = lookahead(g_ext, p_ext, cin, N);
   assign ug   = lookahead(g_ext, p_ext, 1'b0, N);
   assign up   = &gp;

   always_comb begin
      for (int k = 0; k + 1 < N; k++) begin
         // R7
         grp_gen_chk: assert (!gg[k] || cgrp[k+1])
            else $error("group %0d generate did not reach next group", k);
      end
   end

endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder #(
   parameter int unsigned WIDTH   = 16,
   parameter int unsigned GROUP_W = 4
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out,
   output logic             blk_prop,
   output logic             blk_gen
);

   localparam int unsigned NGROUP = WIDTH / GROUP_W;

   if (GROUP_W == 0 || WIDTH % GROUP_W != 0) begin : width_bad
      $error("lookahead_adder: WIDTH must be a multiple of GROUP_W");
   end

   logic [NGROUP-1:0] grp_p;
   logic [NGROUP-1:0] grp_g;
   logic [NGROUP-1:0] grp_cin;

   for (genvar k = 0; k < NGROUP; k++) begin : grp
      cla_group #(.GW(GROUP_W)) i_group (
         .a   (op_a[k*GROUP_W +: GROUP_W]),
         .b   (op_b[k*GROUP_W +: GROUP_W]),
         .cin (grp_cin[k]),
         .s   (sum[k*GROUP_W +: GROUP_W]),
         .bp  (grp_p[k]),
         .bg  (grp_g[k])
      );
   end

   if (NGROUP == 1) begin : single_level
      assign grp_cin   = carry_in;
      assign blk_prop  = grp_p[0];
      assign blk_gen   = grp_g[0];
      assign carry_out = grp_g[0] | (grp_p[0] & carry_in);
   end else begin : two_level
      cla_unit #(.N(NGROUP)) i_unit (
         .gp   (grp_p),
         .gg   (grp_g),
         .cin  (carry_in),
         .cgrp (grp_cin),
         .cout (carry_out),
         .up   (blk_prop),
         .ug   (blk_gen)
      );
   end

   always_comb begin
      // R1
      sum_value_chk: assert ({carry_out, sum} ==
                             ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
         else $error("sum mismatch");
      // R6
      cascade_chk: assert (carry_out == (blk_gen | (blk_prop & carry_in)))
         else $error("carry_out disagrees with exported terms");
      // R4
      word_prop_chk: assert (blk_prop == (&(op_a | op_b)))
         else $error("word propagate wrong");
   end

endmodule

// File: tb/test_lookahead_adder.sv
module test_lookahead_adder;

   logic        clk = 1'b0;
   logic [15:0] op_a = '0;
   logic [15:0] op_b = '0;
   logic        carry_in = 1'b0;
   logic [15:0] sum;
   logic        carry_out;
   logic        blk_prop;
   logic        blk_gen;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [32:0] stim_q[$];

   always #5 clk = ~clk;

   lookahead_adder i_lookahead_adder (
      .op_a      (op_a),
      .op_b      (op_b),
      .carry_in  (carry_in),
      .sum       (sum),
      .carry_out (carry_out),
      .blk_prop  (blk_prop),
      .blk_gen   (blk_gen)
   );

   task automatic check(input string tag, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h (a=%h b=%h cin=%b)",
                  tag, actual, expected, op_a, op_b, carry_in);
      end
   endtask

   task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
      @(posedge clk);
      #1;
      op_a = a; op_b = b; carry_in = c;
      stim_q.push_back({c, a, b});
      @(negedge clk);
   endtask

   // reference model, evaluated at every falling edge after a stimulus
   always @(negedge clk) begin
      if (stim_q.size() > 0) begin
         logic [32:0] st;
         int ia, ib, ic, total;
         st = stim_q.pop_front();
         ic = int'(st[32]);
         ia = int'(st[31:16]);
         ib = int'(st[15:0]);
         total = ia + ib + ic;
         check("R1 sum", int'(sum), total % 65536);
         check("R2 carry_out", int'(carry_out), total / 65536);
         check("R3 blk_gen", int'(blk_gen), (ia + ib) / 65536);
         check("R4 blk_prop", int'(blk_prop), ((ia | ib) == 65535) ? 1 : 0);
         check("R6 cascade", int'(carry_out),
               int'(blk_gen | (blk_prop & carry_in)));
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // reset state: zero inputs
      apply(16'h0000, 16'h0000, 1'b0);
      apply(16'h0000, 16'h0000, 1'b1);
      // R5 full-word carry chain
      apply(16'hFFFF, 16'h0001, 1'b0);
      apply(16'hFFFF, 16'h0000, 1'b1);
      apply(16'hFFFF, 16'hFFFF, 1'b1);
      // alternating propagate patterns (R4, R3 independent of carry_in)
      apply(16'hAAAA, 16'h5555, 1'b0);
      apply(16'hAAAA, 16'h5555, 1'b1);
      apply(16'h5555, 16'h5555, 1'b0);
      apply(16'hAAAA, 16'hAAAA, 1'b1);
      apply(16'hA5A5, 16'h5A5A, 1'b1);
      // R7 group boundary carries
      apply(16'h000F, 16'h0001, 1'b0);
      apply(16'h00F0, 16'h0010, 1'b0);
      apply(16'h0F00, 16'h0100, 1'b0);
      apply(16'hF000, 16'h1000, 1'b0);
      apply(16'h0FFF, 16'h0000, 1'b1);
      // random operands
      for (int n = 0; n < 400; n++) begin
         apply(16'($urandom), 16'($urandom), 1'($urandom));
      end
      @(posedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule